// File: doc/BRIEF.md
# AXI Burst Protection Filter

This block sits between an AXI4 manager and the system interconnect. It checks every read and write burst against a small table of protection regions before the burst goes downstream. A burst may never cross a 4 KB boundary, and every region is a naturally aligned power-of-two block of at least 4 KB. The start address of a burst therefore decides the outcome for every beat in it, and the decision is made combinationally in the cycle the address is presented.

Permitted bursts pass unchanged on all five channels. Refused bursts never appear on the downstream side. For a refused read, the block sends the whole response burst itself, marking every beat as an error. For a refused write, it takes in and drops the data beats, then returns one error response. A refused burst is handled only when no forwarded burst in the same direction is still waiting for its response, so same-ID ordering is kept. Only one refused burst per direction is in progress at a time.

Top module: `axi_prot_filter`

## Requirements
- R1: An address-read request that is permitted appears on the downstream address-read channel with identical id, addr, len, size and burst. Downstream read beats return upstream unchanged (id, data, resp, last).
- R2: A permitted write is forwarded as follows. Its address-write request is passed on unchanged. Its data beats (data, strb, last) follow downstream, and the downstream write response returns upstream unchanged.
- R3: Entry i matches when cfg_en_i[i] is 1 and (addr & M) == (base & M). Here M is that entry's mask with bits 11:0 forced to zero, so the smallest region is 4 KB and the low 12 address bits never take part. Only the burst start address is examined.
- R4: When several entries match, the lowest-numbered one decides. An address that matches no entry is refused.
- R5: Reads use the deciding entry's cfg_rd_i bit and writes use its cfg_wr_i bit. A value of 1 permits the access.
- R6: A refused read is never forwarded. The block returns exactly len+1 beats, each with the original id, resp = 2'b10 (SLVERR) and data zero. Last is 1 on the final beat only. Each beat is held until it is accepted.
- R7: A refused write is never forwarded. Its data beats are accepted up to and including the last one and are not forwarded. The block then presents one write response with the original id and resp = 2'b10, held until accepted.
- R8: While a refused burst of one direction is being completed locally, that direction's upstream address ready stays low.
- R9: A refused burst is accepted only once every forwarded burst of the same direction has received its final response.
- R10: During and right after reset, no valid output is asserted unless an upstream or downstream valid input is driving it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | N_ENT | Entry enable, one bit per entry |
| cfg_base_i | input | N_ENT*ADDR_W | Region base per entry, entry 0 in the low bits |
| cfg_mask_i | input | N_ENT*ADDR_W | Region mask per entry (ones for compared bits) |
| cfg_rd_i | input | N_ENT | Read permission per entry |
| cfg_wr_i | input | N_ENT | Write permission per entry |
| s_aw_valid_i | input | 1 | Upstream write address valid |
| s_aw_ready_o | output | 1 | Upstream write address ready |
| s_aw_id_i | input | ID_W | Upstream write id |
| s_aw_addr_i | input | ADDR_W | Upstream write address |
| s_aw_len_i | input | 8 | Upstream write burst length minus one |
| s_aw_size_i | input | 3 | Upstream write beat size |
| s_aw_burst_i | input | 2 | Upstream write burst type |
| s_w_valid_i | input | 1 | Upstream write data valid |
| s_w_ready_o | output | 1 | Upstream write data ready |
| s_w_data_i | input | DATA_W | Upstream write data |
| s_w_strb_i | input | DATA_W/8 | Upstream write strobes |
| s_w_last_i | input | 1 | Upstream final write beat |
| s_b_valid_o | output | 1 | Upstream write response valid |
| s_b_ready_i | input | 1 | Upstream write response ready |
| s_b_id_o | output | ID_W | Upstream write response id |
| s_b_resp_o | output | 2 | Upstream write response code |
| s_ar_valid_i | input | 1 | Upstream read address valid |
| s_ar_ready_o | output | 1 | Upstream read address ready |
| s_ar_id_i | input | ID_W | Upstream read id |
| s_ar_addr_i | input | ADDR_W | Upstream read address |
| s_ar_len_i | input | 8 | Upstream read burst length minus one |
| s_ar_size_i | input | 3 | Upstream read beat size |
| s_ar_burst_i | input | 2 | Upstream read burst type |
| s_r_valid_o | output | 1 | Upstream read data valid |
| s_r_ready_i | input | 1 | Upstream read data ready |
| s_r_id_o | output | ID_W | Upstream read id |
| s_r_data_o | output | DATA_W | Upstream read data |
| s_r_resp_o | output | 2 | Upstream read response code |
| s_r_last_o | output | 1 | Upstream final read beat |
| m_aw_valid_o | output | 1 | Downstream write address valid |
| m_aw_ready_i | input | 1 | Downstream write address ready |
| m_aw_id_o | output | ID_W | Downstream write id |
| m_aw_addr_o | output | ADDR_W | Downstream write address |
| m_aw_len_o | output | 8 | Downstream write burst length minus one |
| m_aw_size_o | output | 3 | Downstream write beat size |
| m_aw_burst_o | output | 2 | Downstream write burst type |
| m_w_valid_o | output | 1 | Downstream write data valid |
| m_w_ready_i | input | 1 | Downstream write data ready |
| m_w_data_o | output | DATA_W | Downstream write data |
| m_w_strb_o | output | DATA_W/8 | Downstream write strobes |
| m_w_last_o | output | 1 | Downstream final write beat |
| m_b_valid_i | input | 1 | Downstream write response valid |
| m_b_ready_o | output | 1 | Downstream write response ready |
| m_b_id_i | input | ID_W | Downstream write response id |
| m_b_resp_i | input | 2 | Downstream write response code |
| m_ar_valid_o | output | 1 | Downstream read address valid |
| m_ar_ready_i | input | 1 | Downstream read address ready |
| m_ar_id_o | output | ID_W | Downstream read id |
| m_ar_addr_o | output | ADDR_W | Downstream read address |
| m_ar_len_o | output | 8 | Downstream read burst length minus one |
| m_ar_size_o | output | 3 | Downstream read beat size |
| m_ar_burst_o | output | 2 | Downstream read burst type |
| m_r_valid_i | input | 1 | Downstream read data valid |
| m_r_ready_o | output | 1 | Downstream read data ready |
| m_r_id_i | input | ID_W | Downstream read id |
| m_r_data_i | input | DATA_W | Downstream read data |
| m_r_resp_i | input | 2 | Downstream read response code |
| m_r_last_i | input | 1 | Downstream final read beat |

## Verification
The bound checker enforces a set of properties on every cycle:
- Locally generated read beats always carry SLVERR and zero data, and a locally generated beat that is not yet accepted keeps its id and last flag.
- Neither address channel is ready, or forwarded downstream, while a refused burst in that direction is being completed.
- Dropped write data never reaches the downstream port.
- The local write error response is held until accepted.

The directed scenarios are needed for everything else: region priority and the 4 KB mask rule, exact beat counts and the position of last, field-for-field pass-through of permitted bursts, and the ordering stall that keeps a refused read waiting behind an outstanding forwarded one.

// File: rtl/axi_prot_filter_pkg.sv
package axi_prot_filter_pkg;
  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
  localparam int unsigned LEN_W      = 8;
  localparam int unsigned GRAN_LSB   = 12;  // 4 KB minimum region

  typedef enum logic {
    RD_IDLE,
    RD_ERR
  } rd_state_e;

  typedef enum logic [1:0] {
    WR_IDLE,
    WR_FWD,
    WR_DROP,
    WR_RESP
  } wr_state_e;
endpackage

// File: rtl/pf_region_check.sv
module pf_region_check #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned N_ENT    = 4,
  parameter int unsigned GRAN_LSB = 12
) (
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [N_ENT-1:0]        en_i,
  input  logic [N_ENT*ADDR_W-1:0] base_i,
  input  logic [N_ENT*ADDR_W-1:0] mask_i,
  input  logic [N_ENT-1:0]        perm_i,
  output logic                    allow_o
);
  localparam logic [ADDR_W-1:0] GRAN_MASK = ~((ADDR_W'(1) << GRAN_LSB) - ADDR_W'(1));

  logic [N_ENT-1:0] hit;

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    logic [ADDR_W-1:0] m_eff;
    assign m_eff  = mask_i[i*ADDR_W +: ADDR_W] & GRAN_MASK;
    assign hit[i] = en_i[i] &&
                    ((addr_i & m_eff) == (base_i[i*ADDR_W +: ADDR_W] & m_eff));
  end

  // lowest index wins: walk from the top so lower entries overwrite
  always_comb begin
    allow_o = 1'b0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit[i]) allow_o = perm_i[i];
    end
  end
endmodule

// File: rtl/pf_read_path.sv
module pf_read_path
  import axi_prot_filter_pkg::*;
#(
  parameter int unsigned ID_W      = 4,
  parameter int unsigned MAX_OUTST = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             allow_i,
  input  logic             s_ar_valid_i,
  input  logic [ID_W-1:0]  s_ar_id_i,
  input  logic [LEN_W-1:0] s_ar_len_i,
  output logic             s_ar_ready_o,
  output logic             m_ar_valid_o,
  input  logic             m_ar_ready_i,
  input  logic             m_r_valid_i,
  input  logic             m_r_last_i,
  output logic             m_r_ready_o,
  input  logic             s_r_ready_i,
  output logic             loc_valid_o,
  output logic [ID_W-1:0]  loc_id_o,
  output logic             loc_last_o,
  output logic             err_active_o
);
  localparam int unsigned CNT_W = $clog2(MAX_OUTST + 1);

  rd_state_e        state_q, state_d;
  logic [CNT_W-1:0] outst_q;
  logic [ID_W-1:0]  id_q;
  logic [LEN_W-1:0] len_q, beat_q;
  logic             outst_zero, outst_room, fwd_hs, rsp_done, ar_hs, beat_hs;

  assign outst_zero = (outst_q == '0);
  assign outst_room = (outst_q < CNT_W'(MAX_OUTST));

  always_comb begin
    s_ar_ready_o = 1'b0;
    m_ar_valid_o = 1'b0;
    if (state_q == RD_IDLE) begin
      if (allow_i) begin
        m_ar_valid_o = s_ar_valid_i && outst_room;
        s_ar_ready_o = m_ar_ready_i && outst_room;
      end else begin
        s_ar_ready_o = outst_zero;
      end
    end
  end

  assign ar_hs        = s_ar_valid_i && s_ar_ready_o;
  assign fwd_hs       = m_ar_valid_o && m_ar_ready_i;
  assign m_r_ready_o  = (state_q == RD_IDLE) && s_r_ready_i;
  assign rsp_done     = m_r_valid_i && m_r_ready_o && m_r_last_i;
  assign loc_valid_o  = (state_q == RD_ERR);
  assign loc_id_o     = id_q;
  assign loc_last_o   = (beat_q == len_q);
  assign beat_hs      = loc_valid_o && s_r_ready_i;
  assign err_active_o = (state_q == RD_ERR);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RD_IDLE: if (ar_hs && !allow_i) state_d = RD_ERR;
      RD_ERR:  if (beat_hs && loc_last_o) state_d = RD_IDLE;
      default: state_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RD_IDLE;
      outst_q <= '0;
      id_q    <= '0;
      len_q   <= '0;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      if (fwd_hs && !rsp_done)      outst_q <= outst_q + CNT_W'(1);
      else if (!fwd_hs && rsp_done) outst_q <= outst_q - CNT_W'(1);
      if (state_q == RD_IDLE && ar_hs && !allow_i) begin
        id_q   <= s_ar_id_i;
        len_q  <= s_ar_len_i;
        beat_q <= '0;
      end else if (beat_hs) begin
        beat_q <= beat_q + LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/pf_write_path.sv
module pf_write_path
  import axi_prot_filter_pkg::*;
#(
  parameter int unsigned ID_W      = 4,
  parameter int unsigned MAX_OUTST = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            allow_i,
  input  logic            s_aw_valid_i,
  input  logic [ID_W-1:0] s_aw_id_i,
  output logic            s_aw_ready_o,
  output logic            m_aw_valid_o,
  input  logic            m_aw_ready_i,
  input  logic            s_w_valid_i,
  input  logic            s_w_last_i,
  output logic            s_w_ready_o,
  output logic            m_w_valid_o,
  input  logic            m_w_ready_i,
  input  logic            m_b_valid_i,
  output logic            m_b_ready_o,
  input  logic            s_b_ready_i,
  output logic            loc_valid_o,
  output logic [ID_W-1:0] loc_id_o,
  output logic            drop_active_o,
  output logic            resp_active_o
);
  localparam int unsigned CNT_W = $clog2(MAX_OUTST + 1);

  wr_state_e        state_q, state_d;
  logic [CNT_W-1:0] outst_q;
  logic [ID_W-1:0]  id_q;
  logic             outst_zero, outst_room, aw_hs, fwd_hs, rsp_done, w_end;

  assign outst_zero = (outst_q == '0);
  assign outst_room = (outst_q < CNT_W'(MAX_OUTST));

  always_comb begin
    s_aw_ready_o = 1'b0;
    m_aw_valid_o = 1'b0;
    s_w_ready_o  = 1'b0;
    m_w_valid_o  = 1'b0;
    unique case (state_q)
      WR_IDLE: begin
        if (allow_i) begin
          m_aw_valid_o = s_aw_valid_i && outst_room;
          s_aw_ready_o = m_aw_ready_i && outst_room;
        end else begin
          s_aw_ready_o = outst_zero;
        end
      end
      WR_FWD: begin
        m_w_valid_o = s_w_valid_i;
        s_w_ready_o = m_w_ready_i;
      end
      WR_DROP: s_w_ready_o = 1'b1;
      default: ;
    endcase
  end

  assign aw_hs         = s_aw_valid_i && s_aw_ready_o;
  assign fwd_hs        = m_aw_valid_o && m_aw_ready_i;
  assign w_end         = s_w_valid_i && s_w_ready_o && s_w_last_i;
  assign m_b_ready_o   = (state_q != WR_RESP) && s_b_ready_i;
  assign rsp_done      = m_b_valid_i && m_b_ready_o;
  assign loc_valid_o   = (state_q == WR_RESP);
  assign loc_id_o      = id_q;
  assign drop_active_o = (state_q == WR_DROP);
  assign resp_active_o = (state_q == WR_RESP);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WR_IDLE: if (aw_hs) state_d = allow_i ? WR_FWD : WR_DROP;
      WR_FWD:  if (w_end) state_d = WR_IDLE;
      WR_DROP: if (w_end) state_d = WR_RESP;
      WR_RESP: if (s_b_ready_i) state_d = WR_IDLE;
      default: state_d = WR_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WR_IDLE;
      outst_q <= '0;
      id_q    <= '0;
    end else begin
      state_q <= state_d;
      if (fwd_hs && !rsp_done)      outst_q <= outst_q + CNT_W'(1);
      else if (!fwd_hs && rsp_done) outst_q <= outst_q - CNT_W'(1);
      if (state_q == WR_IDLE && aw_hs && !allow_i) id_q <= s_aw_id_i;
    end
  end
endmodule

// File: rtl/axi_prot_filter.sv
module axi_prot_filter
  import axi_prot_filter_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ID_W      = 4,
  parameter int unsigned N_ENT     = 4,
  parameter int unsigned MAX_OUTST = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_ENT-1:0]        cfg_en_i,
  input  logic [N_ENT*ADDR_W-1:0] cfg_base_i,
  input  logic [N_ENT*ADDR_W-1:0] cfg_mask_i,
  input  logic [N_ENT-1:0]        cfg_rd_i,
  input  logic [N_ENT-1:0]        cfg_wr_i,
  input  logic                    s_aw_valid_i,
  output logic                    s_aw_ready_o,
  input  logic [ID_W-1:0]         s_aw_id_i,
  input  logic [ADDR_W-1:0]       s_aw_addr_i,
  input  logic [7:0]              s_aw_len_i,
  input  logic [2:0]              s_aw_size_i,
  input  logic [1:0]              s_aw_burst_i,
  input  logic                    s_w_valid_i,
  output logic                    s_w_ready_o,
  input  logic [DATA_W-1:0]       s_w_data_i,
  input  logic [DATA_W/8-1:0]     s_w_strb_i,
  input  logic                    s_w_last_i,
  output logic                    s_b_valid_o,
  input  logic                    s_b_ready_i,
  output logic [ID_W-1:0]         s_b_id_o,
  output logic [1:0]              s_b_resp_o,
  input  logic                    s_ar_valid_i,
  output logic                    s_ar_ready_o,
  input  logic [ID_W-1:0]         s_ar_id_i,
  input  logic [ADDR_W-1:0]       s_ar_addr_i,
  input  logic [7:0]              s_ar_len_i,
  input  logic [2:0]              s_ar_size_i,
  input  logic [1:0]              s_ar_burst_i,
  output logic                    s_r_valid_o,
  input  logic                    s_r_ready_i,
  output logic [ID_W-1:0]         s_r_id_o,
  output logic [DATA_W-1:0]       s_r_data_o,
  output logic [1:0]              s_r_resp_o,
  output logic                    s_r_last_o,
  output logic                    m_aw_valid_o,
  input  logic                    m_aw_ready_i,
  output logic [ID_W-1:0]         m_aw_id_o,
  output logic [ADDR_W-1:0]       m_aw_addr_o,
  output logic [7:0]              m_aw_len_o,
  output logic [2:0]              m_aw_size_o,
  output logic [1:0]              m_aw_burst_o,
  output logic                    m_w_valid_o,
  input  logic                    m_w_ready_i,
  output logic [DATA_W-1:0]       m_w_data_o,
  output logic [DATA_W/8-1:0]     m_w_strb_o,
  output logic                    m_w_last_o,
  input  logic                    m_b_valid_i,
  output logic                    m_b_ready_o,
  input  logic [ID_W-1:0]         m_b_id_i,
  input  logic [1:0]              m_b_resp_i,
  output logic                    m_ar_valid_o,
  input  logic                    m_ar_ready_i,
  output logic [ID_W-1:0]         m_ar_id_o,
  output logic [ADDR_W-1:0]       m_ar_addr_o,
  output logic [7:0]              m_ar_len_o,
  output logic [2:0]              m_ar_size_o,
  output logic [1:0]              m_ar_burst_o,
  input  logic                    m_r_valid_i,
  output logic                    m_r_ready_o,
  input  logic [ID_W-1:0]         m_r_id_i,
  input  logic [DATA_W-1:0]       m_r_data_i,
  input  logic [1:0]              m_r_resp_i,
  input  logic                    m_r_last_i
);
  logic            rd_allow, wr_allow;
  logic            rd_loc_valid, rd_loc_last, rd_err_active;
  logic [ID_W-1:0] rd_loc_id;
  logic            wr_loc_valid, wr_drop_active, wr_resp_active;
  logic [ID_W-1:0] wr_loc_id;

  pf_region_check #(.ADDR_W(ADDR_W), .N_ENT(N_ENT), .GRAN_LSB(GRAN_LSB)) u_rd_chk (
    .addr_i (s_ar_addr_i), .en_i(cfg_en_i), .base_i(cfg_base_i),
    .mask_i (cfg_mask_i), .perm_i(cfg_rd_i), .allow_o(rd_allow)
  );

  pf_region_check #(.ADDR_W(ADDR_W), .N_ENT(N_ENT), .GRAN_LSB(GRAN_LSB)) u_wr_chk (
    .addr_i (s_aw_addr_i), .en_i(cfg_en_i), .base_i(cfg_base_i),
    .mask_i (cfg_mask_i), .perm_i(cfg_wr_i), .allow_o(wr_allow)
  );

  pf_read_path #(.ID_W(ID_W), .MAX_OUTST(MAX_OUTST)) u_rd (
    .clk_i, .rst_ni,
    .allow_i      (rd_allow),
    .s_ar_valid_i, .s_ar_id_i, .s_ar_len_i,
    .s_ar_ready_o, .m_ar_valid_o, .m_ar_ready_i,
    .m_r_valid_i, .m_r_last_i, .m_r_ready_o, .s_r_ready_i,
    .loc_valid_o  (rd_loc_valid),
    .loc_id_o     (rd_loc_id),
    .loc_last_o   (rd_loc_last),
    .err_active_o (rd_err_active)
  );

  pf_write_path #(.ID_W(ID_W), .MAX_OUTST(MAX_OUTST)) u_wr (
    .clk_i, .rst_ni,
    .allow_i       (wr_allow),
    .s_aw_valid_i, .s_aw_id_i, .s_aw_ready_o, .m_aw_valid_o, .m_aw_ready_i,
    .s_w_valid_i, .s_w_last_i, .s_w_ready_o, .m_w_valid_o, .m_w_ready_i,
    .m_b_valid_i, .m_b_ready_o, .s_b_ready_i,
    .loc_valid_o   (wr_loc_valid),
    .loc_id_o      (wr_loc_id),
    .drop_active_o (wr_drop_active),
    .resp_active_o (wr_resp_active)
  );

  assign m_ar_id_o    = s_ar_id_i;
  assign m_ar_addr_o  = s_ar_addr_i;
  assign m_ar_len_o   = s_ar_len_i;
  assign m_ar_size_o  = s_ar_size_i;
  assign m_ar_burst_o = s_ar_burst_i;
  assign m_aw_id_o    = s_aw_id_i;
  assign m_aw_addr_o  = s_aw_addr_i;
  assign m_aw_len_o   = s_aw_len_i;
  assign m_aw_size_o  = s_aw_size_i;
  assign m_aw_burst_o = s_aw_burst_i;
  assign m_w_data_o   = s_w_data_i;
  assign m_w_strb_o   = s_w_strb_i;
  assign m_w_last_o   = s_w_last_i;

  // downstream has nothing pending while a local response runs
  assign s_r_valid_o = rd_err_active ? rd_loc_valid : m_r_valid_i;
  assign s_r_id_o    = rd_err_active ? rd_loc_id    : m_r_id_i;
  assign s_r_data_o  = rd_err_active ? '0           : m_r_data_i;
  assign s_r_resp_o  = rd_err_active ? RESP_SLVERR  : m_r_resp_i;
  assign s_r_last_o  = rd_err_active ? rd_loc_last  : m_r_last_i;

  assign s_b_valid_o = wr_resp_active ? wr_loc_valid : m_b_valid_i;
  assign s_b_id_o    = wr_resp_active ? wr_loc_id    : m_b_id_i;
  assign s_b_resp_o  = wr_resp_active ? RESP_SLVERR  : m_b_resp_i;
endmodule

// File: rtl/axi_prot_filter_chk.sv
module axi_prot_filter_chk
  import axi_prot_filter_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ID_W   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_err_active,
  input logic              wr_drop_active,
  input logic              wr_resp_active,
  input logic              s_ar_ready_o,
  input logic              m_ar_valid_o,
  input logic              s_aw_ready_o,
  input logic              m_aw_valid_o,
  input logic              m_w_valid_o,
  input logic              s_r_valid_o,
  input logic              s_r_ready_i,
  input logic [1:0]        s_r_resp_o,
  input logic [DATA_W-1:0] s_r_data_o,
  input logic              s_r_last_o,
  input logic [ID_W-1:0]   s_r_id_o,
  input logic              s_b_valid_o,
  input logic              s_b_ready_i,
  input logic [1:0]        s_b_resp_o,
  input logic [ID_W-1:0]   s_b_id_o
);
  assert_rd_err_beat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_active && s_r_valid_o |-> s_r_resp_o == RESP_SLVERR && s_r_data_o == '0);

  assert_rd_err_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_active && s_r_valid_o && !s_r_ready_i |=>
      s_r_valid_o && $stable(s_r_last_o) && $stable(s_r_id_o));

  assert_rd_addr_block_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_active |-> !s_ar_ready_o && !m_ar_valid_o);

  assert_wr_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_drop_active |-> !m_w_valid_o && !m_aw_valid_o);

  assert_wr_err_resp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_resp_active |-> s_b_valid_o && s_b_resp_o == RESP_SLVERR);

  assert_wr_resp_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_resp_active && !s_b_ready_i |=> wr_resp_active && $stable(s_b_id_o));

  assert_wr_addr_block_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_drop_active || wr_resp_active |-> !s_aw_ready_o);
endmodule

bind axi_prot_filter axi_prot_filter_chk #(.DATA_W(DATA_W), .ID_W(ID_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .rd_err_active  (rd_err_active),
  .wr_drop_active (wr_drop_active),
  .wr_resp_active (wr_resp_active),
  .s_ar_ready_o   (s_ar_ready_o),
  .m_ar_valid_o   (m_ar_valid_o),
  .s_aw_ready_o   (s_aw_ready_o),
  .m_aw_valid_o   (m_aw_valid_o),
  .m_w_valid_o    (m_w_valid_o),
  .s_r_valid_o    (s_r_valid_o),
  .s_r_ready_i    (s_r_ready_i),
  .s_r_resp_o     (s_r_resp_o),
  .s_r_data_o     (s_r_data_o),
  .s_r_last_o     (s_r_last_o),
  .s_r_id_o       (s_r_id_o),
  .s_b_valid_o    (s_b_valid_o),
  .s_b_ready_i    (s_b_ready_i),
  .s_b_resp_o     (s_b_resp_o),
  .s_b_id_o       (s_b_id_o)
);

// File: tb/axi_prot_filter_tb.sv
module axi_prot_filter_tb;
  localparam int AW = 32, DW = 32, IW = 4, NE = 4;
  localparam int NVEC = 13;
  // {is_write, addr, len, id, expect_allow}
  localparam logic [45:0] VEC [NVEC] = '{
    {1'b0, 32'h1000_0040, 8'd3, 4'd1, 1'b0},
    {1'b0, 32'h1000_1000, 8'd1, 4'd2, 1'b1},
    {1'b1, 32'h1000_2000, 8'd2, 4'd3, 1'b1},
    {1'b1, 32'h1000_0FF0, 8'd0, 4'd4, 1'b0},
    {1'b0, 32'h2000_8000, 8'd2, 4'd5, 1'b1},
    {1'b1, 32'h2000_8000, 8'd1, 4'd6, 1'b0},
    {1'b1, 32'h3000_0ABC, 8'd0, 4'd7, 1'b1},
    {1'b0, 32'h3000_0ABC, 8'd0, 4'd8, 1'b0},
    {1'b0, 32'h3000_1000, 8'd0, 4'd9, 1'b0},
    {1'b0, 32'h4000_0000, 8'd7, 4'd10, 1'b0},
    {1'b1, 32'h1008_0000, 8'd3, 4'd11, 1'b1},
    {1'b0, 32'h100F_FFC0, 8'd0, 4'd12, 1'b1},
    {1'b0, 32'h1010_0000, 8'd0, 4'd13, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NE-1:0] cfg_en, cfg_rd, cfg_wr;
  logic [NE*AW-1:0] cfg_base, cfg_mask;
  logic s_aw_valid, s_aw_ready, s_w_valid, s_w_ready, s_w_last, s_b_valid, s_b_ready;
  logic [IW-1:0] s_aw_id, s_b_id, s_ar_id, s_r_id;
  logic [AW-1:0] s_aw_addr, s_ar_addr;
  logic [7:0] s_aw_len, s_ar_len;
  logic [2:0] s_aw_size, s_ar_size;
  logic [1:0] s_aw_burst, s_ar_burst, s_b_resp, s_r_resp;
  logic [DW-1:0] s_w_data, s_r_data;
  logic [DW/8-1:0] s_w_strb;
  logic s_ar_valid, s_ar_ready, s_r_valid, s_r_ready, s_r_last;
  logic m_aw_valid, m_aw_ready, m_w_valid, m_w_ready, m_w_last, m_b_valid, m_b_ready;
  logic [IW-1:0] m_aw_id, m_b_id, m_ar_id, m_r_id;
  logic [AW-1:0] m_aw_addr, m_ar_addr;
  logic [7:0] m_aw_len, m_ar_len;
  logic [2:0] m_aw_size, m_ar_size;
  logic [1:0] m_aw_burst, m_ar_burst, m_b_resp, m_r_resp;
  logic [DW-1:0] m_w_data, m_r_data;
  logic [DW/8-1:0] m_w_strb;
  logic m_ar_valid, m_ar_ready, m_r_valid, m_r_ready, m_r_last;

  axi_prot_filter #(.ADDR_W(AW), .DATA_W(DW), .ID_W(IW), .N_ENT(NE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_en_i(cfg_en), .cfg_base_i(cfg_base), .cfg_mask_i(cfg_mask),
    .cfg_rd_i(cfg_rd), .cfg_wr_i(cfg_wr),
    .s_aw_valid_i(s_aw_valid), .s_aw_ready_o(s_aw_ready), .s_aw_id_i(s_aw_id),
    .s_aw_addr_i(s_aw_addr), .s_aw_len_i(s_aw_len), .s_aw_size_i(s_aw_size),
    .s_aw_burst_i(s_aw_burst),
    .s_w_valid_i(s_w_valid), .s_w_ready_o(s_w_ready), .s_w_data_i(s_w_data),
    .s_w_strb_i(s_w_strb), .s_w_last_i(s_w_last),
    .s_b_valid_o(s_b_valid), .s_b_ready_i(s_b_ready), .s_b_id_o(s_b_id), .s_b_resp_o(s_b_resp),
    .s_ar_valid_i(s_ar_valid), .s_ar_ready_o(s_ar_ready), .s_ar_id_i(s_ar_id),
    .s_ar_addr_i(s_ar_addr), .s_ar_len_i(s_ar_len), .s_ar_size_i(s_ar_size),
    .s_ar_burst_i(s_ar_burst),
    .s_r_valid_o(s_r_valid), .s_r_ready_i(s_r_ready), .s_r_id_o(s_r_id),
    .s_r_data_o(s_r_data), .s_r_resp_o(s_r_resp), .s_r_last_o(s_r_last),
    .m_aw_valid_o(m_aw_valid), .m_aw_ready_i(m_aw_ready), .m_aw_id_o(m_aw_id),
    .m_aw_addr_o(m_aw_addr), .m_aw_len_o(m_aw_len), .m_aw_size_o(m_aw_size),
    .m_aw_burst_o(m_aw_burst),
    .m_w_valid_o(m_w_valid), .m_w_ready_i(m_w_ready), .m_w_data_o(m_w_data),
    .m_w_strb_o(m_w_strb), .m_w_last_o(m_w_last),
    .m_b_valid_i(m_b_valid), .m_b_ready_o(m_b_ready), .m_b_id_i(m_b_id), .m_b_resp_i(m_b_resp),
    .m_ar_valid_o(m_ar_valid), .m_ar_ready_i(m_ar_ready), .m_ar_id_o(m_ar_id),
    .m_ar_addr_o(m_ar_addr), .m_ar_len_o(m_ar_len), .m_ar_size_o(m_ar_size),
    .m_ar_burst_o(m_ar_burst),
    .m_r_valid_i(m_r_valid), .m_r_ready_o(m_r_ready), .m_r_id_i(m_r_id),
    .m_r_data_i(m_r_data), .m_r_resp_i(m_r_resp), .m_r_last_i(m_r_last)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    s_aw_valid = 0; s_w_valid = 0; s_b_ready = 0; s_ar_valid = 0; s_r_ready = 0;
    m_aw_ready = 0; m_w_ready = 0; m_b_valid = 0; m_ar_ready = 0; m_r_valid = 0;
    s_w_last = 0; m_r_last = 0; m_b_resp = 2'b00; m_r_resp = 2'b00;
    m_b_id = '0; m_r_id = '0; m_r_data = '0; s_w_data = '0; s_w_strb = '1;
    s_aw_size = 3'd2; s_ar_size = 3'd2; s_aw_burst = 2'b01; s_ar_burst = 2'b01;
  endtask

  task automatic do_read(input logic [31:0] addr, input logic [7:0] len,
                         input logic [3:0] id, input bit allow);
    @(negedge clk);
    s_ar_valid = 1; s_ar_addr = addr; s_ar_len = len; s_ar_id = id; m_ar_ready = 1;
    #1;
    chk(m_ar_valid == allow, "R3/R4/R5 read decision", 64'(m_ar_valid), 64'(allow));
    chk(s_ar_ready == 1'b1, "R9 read addr ready when idle", 64'(s_ar_ready), 64'd1);
    if (allow)
      chk(m_ar_addr == addr && m_ar_len == len && m_ar_id == id && m_ar_size == 3'd2
          && m_ar_burst == 2'b01, "R1 read request fields", 64'(m_ar_addr), 64'(addr));
    @(negedge clk);
    s_ar_valid = 0; m_ar_ready = 0; s_r_ready = 1;
    for (int b = 0; b <= int'(len); b++) begin
      if (allow) begin
        m_r_valid = 1; m_r_id = id; m_r_data = 32'hA500_0000 | (b << 8) | 32'(id);
        m_r_resp = 2'b00; m_r_last = (b == int'(len));
      end
      #1;
      if (allow) begin
        chk(s_r_valid && s_r_data == m_r_data && s_r_id == id && s_r_resp == 2'b00
            && s_r_last == (b == int'(len)), "R1 read beat pass", 64'(s_r_data), 64'(m_r_data));
      end else begin
        chk(s_r_valid && s_r_resp == 2'b10 && s_r_data == '0 && s_r_id == id,
            "R6 error beat", {30'd0, s_r_resp, s_r_data}, {30'd0, 2'b10, 32'd0});
        chk(s_r_last == (b == int'(len)), "R6 last position", 64'(s_r_last),
            64'(b == int'(len)));
        chk(!s_ar_ready && !m_ar_valid, "R8 read addr held off", 64'(s_ar_ready), 64'd0);
      end
      @(negedge clk);
    end
    m_r_valid = 0; m_r_last = 0;
    #1;
    chk(!s_r_valid, "R6 beat count", 64'(s_r_valid), 64'd0);
    s_r_ready = 0;
  endtask

  task automatic do_write(input logic [31:0] addr, input logic [7:0] len,
                          input logic [3:0] id, input bit allow);
    @(negedge clk);
    s_aw_valid = 1; s_aw_addr = addr; s_aw_len = len; s_aw_id = id; m_aw_ready = 1;
    #1;
    chk(m_aw_valid == allow, "R3/R4/R5 write decision", 64'(m_aw_valid), 64'(allow));
    if (allow)
      chk(m_aw_addr == addr && m_aw_len == len && m_aw_id == id && m_aw_burst == 2'b01,
          "R2 write request fields", 64'(m_aw_addr), 64'(addr));
    @(negedge clk);
    s_aw_valid = 0; m_aw_ready = 0; m_w_ready = 1;
    for (int b = 0; b <= int'(len); b++) begin
      s_w_valid = 1; s_w_data = 32'hC0DE_0000 + 32'(b); s_w_strb = 4'(b + 1);
      s_w_last = (b == int'(len));
      #1;
      chk(s_w_ready == 1'b1, "R2/R7 write beat accepted", 64'(s_w_ready), 64'd1);
      if (allow)
        chk(m_w_valid && m_w_data == s_w_data && m_w_strb == s_w_strb && m_w_last == s_w_last,
            "R2 write beat pass", 64'(m_w_data), 64'(s_w_data));
      else begin
        chk(!m_w_valid, "R7 write beat dropped", 64'(m_w_valid), 64'd0);
        chk(!s_aw_ready, "R8 write addr held off", 64'(s_aw_ready), 64'd0);
      end
      @(negedge clk);
    end
    s_w_valid = 0; s_w_last = 0; m_w_ready = 0; s_b_ready = 1;
    if (allow) begin
      m_b_valid = 1; m_b_id = id; m_b_resp = 2'b00;
    end
    #1;
    if (allow)
      chk(s_b_valid && s_b_id == id && s_b_resp == 2'b00 && m_b_ready,
          "R2 write response pass", 64'(s_b_resp), 64'd0);
    else
      chk(s_b_valid && s_b_id == id && s_b_resp == 2'b10, "R7 error write response",
          {s_b_valid, s_b_id, s_b_resp}, {1'b1, id, 2'b10});
    @(negedge clk);
    m_b_valid = 0;
    #1;
    chk(!s_b_valid, "R7 single write response", 64'(s_b_valid), 64'd0);
    s_b_ready = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    s_ar_addr = '0; s_ar_len = '0; s_ar_id = '0; s_aw_addr = '0; s_aw_len = '0; s_aw_id = '0;
    cfg_en = 4'b1111;
    cfg_base = {32'h3000_0000, 32'h2000_0000, 32'h1000_0000, 32'h1000_0000};
    cfg_mask = {32'hFFFF_FFFF, 32'hFFFF_0000, 32'hFFF0_0000, 32'hFFFF_F000};
    cfg_rd   = 4'b0110;
    cfg_wr   = 4'b1010;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!m_ar_valid && !m_aw_valid && !m_w_valid && !s_r_valid && !s_b_valid,
        "R10 valids low in reset", {m_ar_valid, m_aw_valid, m_w_valid, s_r_valid, s_b_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!m_ar_valid && !m_aw_valid && !m_w_valid && !s_r_valid && !s_b_valid,
        "R10 valids low after reset", {m_ar_valid, m_aw_valid, m_w_valid, s_r_valid, s_b_valid}, 0);

    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][45]) do_write(VEC[v][44:13], VEC[v][12:5], VEC[v][4:1], VEC[v][0]);
      else            do_read (VEC[v][44:13], VEC[v][12:5], VEC[v][4:1], VEC[v][0]);
    end

    // R4: disabling the deny page lets entry 1 grant the same read
    cfg_en = 4'b1110;
    do_read(32'h1000_0040, 8'd0, 4'd14, 1'b1);
    cfg_en = 4'b1111;

    // R9: refused read waits for an outstanding forwarded read
    @(negedge clk);
    s_ar_valid = 1; s_ar_addr = 32'h1000_1000; s_ar_len = 0; s_ar_id = 4'd5; m_ar_ready = 1;
    @(negedge clk);
    s_ar_addr = 32'h4000_0000; s_ar_id = 4'd6;
    #1;
    chk(!s_ar_ready && !m_ar_valid, "R9 refused read stalls", 64'(s_ar_ready), 64'd0);
    @(negedge clk);
    #1;
    chk(!s_r_valid, "R9 no local beat while pending", 64'(s_r_valid), 64'd0);
    m_r_valid = 1; m_r_last = 1; m_r_id = 4'd5; m_r_data = 32'h1234_5678; s_r_ready = 1;
    #1;
    chk(s_r_valid && s_r_id == 4'd5 && s_r_data == 32'h1234_5678, "R9 forwarded beat first",
        64'(s_r_data), 64'h1234_5678);
    @(negedge clk);
    m_r_valid = 0; m_r_last = 0;
    #1;
    chk(s_ar_ready, "R9 refused read accepted after drain", 64'(s_ar_ready), 64'd1);
    @(negedge clk);
    s_ar_valid = 0; m_ar_ready = 0;
    #1;
    chk(s_r_valid && s_r_id == 4'd6 && s_r_resp == 2'b10 && s_r_last,
        "R6 local beat after drain", {s_r_valid, s_r_id, s_r_resp}, {1'b1, 4'd6, 2'b10});
    // R6 hold under backpressure
    s_r_ready = 0;
    @(negedge clk);
    #1;
    chk(s_r_valid && s_r_last && s_r_id == 4'd6, "R6 beat held", 64'(s_r_valid), 64'd1);
    s_r_ready = 1;
    @(negedge clk);
    #1;
    chk(!s_r_valid, "R6 one beat for len 0", 64'(s_r_valid), 64'd0);
    s_r_ready = 0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule